// File: doc/BRIEF.md
# PCI Interrupt Link Steering Router

This block connects four active-low PCI interrupt links to eight legacy interrupt request outputs. Software programs the routing through a small register port: a steering register gives each link a target index and holds an enable bit per target, an assertion-level register picks level or edge signalling per target, and a power-management assertion register keeps a spare copy of trigger settings for other logic to use.

Target index k drives `irq_out[k]`. The legacy IRQ numbers behind the indices are, from index 0 up: 3, 5, 9, 10, 11, 12, 14, 15. Requests from links that share a target are ORed together. A target in level mode follows that OR one cycle after the links are sampled. A target in edge mode gives a one-cycle pulse when the OR rises.

Top module: `pci_irq_steer`

## Requirements
- R1: After reset all three registers read as zero, no link is routed, every target is in edge mode and `irq_out` is zero.
- R2: The steering register is at address 0x74, the assertion-level register at 0x5C and the power-management register at 0x78. A read of any other address returns zero, and a write to any other address changes no register.
- R3: In the steering register, link n (n = 0..3, the bit of `link_n`) takes its target index from bits [4n+2:4n]. Bit 4n+3 and bits [31:24] read as zero, and writes to them are dropped, so the read-back mask is 0x00FF7777.
- R4: Steering bits [23:16] enable targets, with bit 16+k for target k. A link whose selected target is not enabled drives no output.
- R5: A link is requesting while its `link_n` bit is 0. The request of a target is the OR of all enabled links that select it.
- R6: When bit k of the assertion-level register is 1 (level mode), `irq_out[k]` equals the target's request as sampled at the previous rising clock edge.
- R7: When bit k is 0 (edge mode), `irq_out[k]` is high for exactly one cycle after the sampled request rises from 0 to 1, and stays low while the request is held.
- R8: The assertion-level register stores only bits [7:0]. Its other bits read as zero.
- R9: The power-management register stores and returns all 32 bits and has no effect on `irq_out`.
- R10: The trigger mode belongs to the target, so links routed to different targets can work in different modes at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Register address, used for both reads and writes |
| cfg_wr | input | 1 | Write strobe; `cfg_wdata` is stored at the clock edge |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| link_n | input | 4 | Active-low interrupt links 0..3 |
| irq_out | output | 8 | One request output per target index |

## Verification
The assertions are checked on every cycle. They cover four points: when no link was requesting, or no target was enabled, in the previous cycle, the outputs must be quiet. An edge-mode pulse never lasts a second cycle. Writes to unmapped addresses leave the stored settings unchanged. The reserved steering bits always read zero. The bench's scenarios are needed for the rest: the mapping of each field to its target, level outputs that follow a held request, OR sharing that makes no new edge, a mix of modes across targets, and confirming that the power-management register has no effect on the outputs.

// File: rtl/pci_irq_steer.sv
module pci_irq_steer #(
  parameter logic [7:0] STEER_ADDR = 8'h74,
  parameter logic [7:0] TRIG_ADDR  = 8'h5C,
  parameter logic [7:0] PM_ADDR    = 8'h78,
  parameter int         NLINK      = 4,
  parameter int         NTGT       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_addr,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [NLINK-1:0]  link_n,
  output logic [NTGT-1:0]   irq_out
);
  localparam logic [31:0] STEER_MASK = 32'h00FF_7777;
  localparam int          IW         = $clog2(NTGT);

  logic [31:0]     steer_q;
  logic [NTGT-1:0] trig_q;
  logic [31:0]     pm_q;
  logic [NTGT-1:0] req, req_q, req_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      steer_q <= '0;
      trig_q  <= '0;
      pm_q    <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == STEER_ADDR) steer_q <= cfg_wdata & STEER_MASK;
      if (cfg_addr == TRIG_ADDR)  trig_q  <= cfg_wdata[NTGT-1:0];
      if (cfg_addr == PM_ADDR)    pm_q    <= cfg_wdata;
    end
  end

  wire [NTGT-1:0] tgt_en = steer_q[16 +: NTGT];

  always_comb begin
    req = '0;
    for (int n = 0; n < NLINK; n++) begin
      if (!link_n[n] && tgt_en[steer_q[4*n +: IW]])
        req[steer_q[4*n +: IW]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      req_d <= '0;
    end else begin
      req_q <= req;
      req_d <= req_q;
    end
  end

  assign irq_out = req_q & (trig_q | ~req_d);

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == STEER_ADDR)     cfg_rdata = steer_q;
    else if (cfg_addr == TRIG_ADDR) cfg_rdata = {{(32-NTGT){1'b0}}, trig_q};
    else if (cfg_addr == PM_ADDR)   cfg_rdata = pm_q;
  end
endmodule

// File: rtl/pci_irq_steer_chk.sv
module pci_irq_steer_chk #(
  parameter logic [7:0] STEER_ADDR = 8'h74,
  parameter logic [7:0] TRIG_ADDR  = 8'h5C,
  parameter logic [7:0] PM_ADDR    = 8'h78
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_addr,
  input logic        cfg_wr,
  input logic [31:0] cfg_rdata,
  input logic [3:0]  link_n,
  input logic [7:0]  irq_out,
  input logic [31:0] steer_q,
  input logic [7:0]  trig_q,
  input logic [31:0] pm_q
);
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(link_n)) |-> (irq_out == 8'h00));

  assert_no_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(steer_q[23:16]) == 8'h00) |-> (irq_out == 8'h00));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == STEER_ADDR) |-> ((cfg_rdata & ~32'h00FF_7777) == 32'h0));

  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr != STEER_ADDR && cfg_addr != TRIG_ADDR && cfg_addr != PM_ADDR)
    |=> ($stable(steer_q) && $stable(trig_q) && $stable(pm_q)));

  for (genvar k = 0; k < 8; k++) begin : g_edge
    assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_q[k] && $past(!trig_q[k]) && $past(irq_out[k])) |-> !irq_out[k]);
  end
endmodule

bind pci_irq_steer pci_irq_steer_chk #(
  .STEER_ADDR(STEER_ADDR), .TRIG_ADDR(TRIG_ADDR), .PM_ADDR(PM_ADDR)
) u_chk (.*);

// File: tb/pci_irq_steer_tb.sv
module pci_irq_steer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [3:0]  link_n;
  logic [7:0]  irq_out;

  pci_irq_steer u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] steer_m = 0, trig_m = 0, pm_m = 0;
  logic [7:0]  m_req = 0, m_prev = 0;

  function automatic logic [7:0] reqf(logic [3:0] l, logic [31:0] s);
    logic [7:0] r = 0;
    for (int n = 0; n < 4; n++) begin
      logic [2:0] idx = s[4*n +: 3];
      if (!l[n] && s[16 + idx]) r[idx] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [7:0] expf();
    return (m_req & trig_m[7:0]) | (m_req & ~trig_m[7:0] & ~m_prev);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    m_prev = m_req;
    m_req  = reqf(link_n, steer_m);
    if (cfg_wr) begin
      if (cfg_addr == 8'h74) steer_m = cfg_wdata & 32'h00FF_7777;
      if (cfg_addr == 8'h5C) trig_m  = {24'h0, cfg_wdata[7:0]};
      if (cfg_addr == 8'h78) pm_m    = cfg_wdata;
    end
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic chk_irq(string tag);
    chk(irq_out == expf(), tag, {24'h0, irq_out}, {24'h0, expf()});
  endtask

  task automatic step(logic [3:0] l, string tag);
    link_n = l;
    cycle();
    chk_irq(tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    cycle();
    chk_irq(tag);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == e, tag, cfg_rdata, e);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; link_n = 4'hF; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(8'h74, 0, "R1 steer"); rd(8'h5C, 0, "R1 trig"); rd(8'h78, 0, "R1 pm");
    step(4'h0, "R1 unrouted links");
    chk(irq_out == 0, "R1 irq", {24'h0, irq_out}, 0);
    step(4'hF, "R1");

    // R3 field layout and masking: link0->0, link1->3, link2->3, link3->7; enable 0,3
    wr(8'h74, 32'hFF09_FBB8, "R3 write");
    rd(8'h74, 32'h0009_7330, "R3 readback");

    // R7 edge pulse, R4 disabled target, R5 sharing
    step(4'hE, "R7 rise link0");
    chk(irq_out == 8'h01, "R7 pulse", {24'h0, irq_out}, 32'h01);
    step(4'hE, "R7 held");
    chk(irq_out == 8'h00, "R7 held low", {24'h0, irq_out}, 0);
    step(4'hF, "R7");
    step(4'h7, "R4 disabled target");
    chk(irq_out == 8'h00, "R4 no output", {24'h0, irq_out}, 0);
    step(4'hD, "R5 link1");
    chk(irq_out == 8'h08, "R5 pulse idx3", {24'h0, irq_out}, 32'h08);
    step(4'h9, "R5 share no new edge");
    chk(irq_out == 8'h00, "R5 shared OR", {24'h0, irq_out}, 0);
    step(4'hB, "R5 link2 alone");
    step(4'hF, "R5 release");
    step(4'hB, "R5 link2 new rise");
    chk(irq_out == 8'h08, "R5 link2 pulse", {24'h0, irq_out}, 32'h08);
    step(4'hF, "R5");

    // R8 and R6 level mode
    wr(8'h5C, 32'hFFFF_FF09, "R8 write");
    rd(8'h5C, 32'h0000_0009, "R8 readback");
    for (int i = 0; i < 4; i++) begin
      step(4'hE, "R6 level held");
      chk(irq_out == 8'h01, "R6 level", {24'h0, irq_out}, 32'h01);
    end
    step(4'hF, "R6 release");
    chk(irq_out == 8'h00, "R6 drop", {24'h0, irq_out}, 0);

    // R10 mixed modes: enable idx7 (edge) alongside idx0 (level)
    wr(8'h74, 32'h0089_7330, "R10 write");
    step(4'h6, "R10 both");
    chk(irq_out == 8'h81, "R10 first", {24'h0, irq_out}, 32'h81);
    step(4'h6, "R10 held");
    chk(irq_out == 8'h01, "R10 second", {24'h0, irq_out}, 32'h01);
    step(4'hF, "R10");

    // R9 power-management storage, R2 unmapped address
    step(4'hE, "R9 pre");
    wr(8'h78, 32'hDEAD_BEEF, "R9 no effect");
    rd(8'h78, 32'hDEAD_BEEF, "R9 readback");
    step(4'hE, "R9 outputs");
    wr(8'h70, 32'hFFFF_FFFF, "R2 unmapped write");
    rd(8'h70, 0, "R2 unmapped read");
    rd(8'h74, 32'h0089_7330, "R2 steer kept");
    rd(8'h5C, 32'h0000_0009, "R2 trig kept");
    rd(8'h78, 32'hDEAD_BEEF, "R2 pm kept");
    step(4'hF, "R2");

    // random phase
    for (int i = 0; i < 600; i++) begin
      int sel = $urandom % 10;
      if (sel == 0)      wr(8'h74, $urandom, "R4 random steer");
      else if (sel == 1) wr(8'h5C, $urandom, "R6 random trig");
      else if (sel == 2) wr(8'h78, $urandom, "R9 random pm");
      else               step(4'($urandom), "R7 random links");
      if (sel == 0) rd(8'h74, steer_m, "R3 random readback");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule